// File: doc/BRIEF.md
# Prescaled Reloading Wake-Up Timer

This block is a slow system timer meant to keep time while the rest of the chip sleeps. A 7-bit prescaler counts down once per selected time-base tick. Each time the prescaler passes through zero, a 16-bit down counter steps by one. When both stages are zero, the next tick reloads the 16-bit stage from a programmable reload register and restarts the prescaler at 127. It also sets a sticky event flag. The flag drives an interrupt request and a wake-up request, each gated by its own enable.

The time base comes as two single-cycle tick strobes in the block's clock domain: one derived from the core clock and one from the crystal oscillator. A select bit picks between them. When the crystal is driving the CPU, the core-clock tick is used whatever the select bit says. A small controller with three states sequences the counter. `ST_OFF` is idle with the count frozen. `ST_LOAD` is a single cycle that copies the reload value into the chain. `ST_RUN` is counting. Its transitions are: enable seen → `ST_LOAD`; `ST_LOAD` → `ST_RUN` while still enabled (or back to `ST_OFF`); `ST_RUN` → `ST_OFF` when the enable clears.

Only the power-on reset input clears the block. No other reset reaches it, so the count and settings survive a warm reset elsewhere in the chip.

Top module: `rtc_wake_timer`

## Requirements
- R1: While `por_n` is low, the prescaler reads 127, the main count reads the reset reload value 16'hFFFF, and the flag, interrupt and wake outputs are 0, with the controller in `ST_OFF`.
- R2: In `ST_RUN`, each cycle with the selected tick high lowers the prescaler by one. When the prescaler is 0, it goes to 127 instead and the main count drops by one. The main count never changes while the prescaler is nonzero.
- R3: A tick in `ST_RUN` with prescaler and main count both 0 loads the main count from the reload register, sets the prescaler to 127 and sets the flag. One full period is therefore (reload+1)×128 ticks.
- R4: With `cfg_src_xtal` = 0 only `core_tick` advances the chain. With `cfg_src_xtal` = 1 only `xtal_tick` does.
- R5: While `xtal_is_cpu` = 1, only `core_tick` advances the chain, regardless of `cfg_src_xtal`.
- R6: The flag stays 1 until a cycle with `flag_clr` = 1, and it reads 0 from the following cycle. If a zero event and `flag_clr` fall in the same cycle, the flag is set.
- R7: `irq_o` equals flag AND the interrupt enable. `wake_o` equals flag AND the wake enable.
- R8: One cycle after a `cfg_we` write with `cfg_run` = 1, the controller enters `ST_LOAD`. On the following cycle the prescaler reads 127 and the main count reads the reload value. Ticks are counted from the cycle after that. After a write with `cfg_run` = 0, counting stops within two cycles and the values then hold.
- R9: Writing the reload register while running leaves the current count unchanged. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_tick | input | 1 | Time-base strobe derived from the core clock |
| xtal_tick | input | 1 | Time-base strobe derived from the crystal oscillator |
| xtal_is_cpu | input | 1 | Crystal currently drives the CPU; forces core_tick |
| cfg_we | input | 1 | Write strobe for the control settings |
| cfg_run | input | 1 | Enable value written by cfg_we |
| cfg_src_xtal | input | 1 | Source select written by cfg_we (1 = crystal) |
| cfg_wake_en | input | 1 | Wake enable written by cfg_we |
| cfg_irq_en | input | 1 | Interrupt enable written by cfg_we |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_val | input | 16 | Reload value written by rld_we |
| flag_clr | input | 1 | Software clear of the event flag |
| pre_o | output | 7 | Current prescaler value |
| cnt_o | output | 16 | Current main count |
| flag_o | output | 1 | Sticky zero-event flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Two functions can fall in the same cycle: the zero event that sets the flag and the software clear that drops it. The bench programs a reload of zero and counts 127 ticks from the load, so that the chain sits at all-zero. In that exact cycle it raises `flag_clr`. A correct block shows the flag high, the prescaler at 127 and the count reloaded on the next sample. A second point of overlap, a reload write in mid-count, is judged by confirming that the running count is untouched and that the new value appears only after the full remaining wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // controller states of the wake-up timer
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } rtc_state_e;
endpackage

// File: rtl/rtc_clk_pick.sv
module rtc_clk_pick (
    input  logic core_tick,
    input  logic xtal_tick,
    input  logic src_xtal,
    input  logic xtal_is_cpu,
    output logic tick
);
    // crystal is only usable when it is not the CPU clock
    logic use_xtal;
    assign use_xtal = src_xtal && !xtal_is_cpu;
    assign tick     = use_xtal ? xtal_tick : core_tick;
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_CNT = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic [PRE_W-1:0] pre_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero_evt
);
    localparam logic [PRE_W-1:0] PRE_TOP = '1;

    logic pre_zero;
    logic cnt_zero;
    assign pre_zero = (pre_q == '0);
    assign cnt_zero = (cnt_q == '0);
    assign zero_evt = step && pre_zero && cnt_zero;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= PRE_TOP;
            cnt_q <= RST_CNT;
        end else if (load) begin
            pre_q <= PRE_TOP;
            cnt_q <= reload;
        end else if (step) begin
            if (pre_zero) begin
                pre_q <= PRE_TOP;
                cnt_q <= cnt_zero ? reload : cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             core_tick,
    input  logic             xtal_tick,
    input  logic             xtal_is_cpu,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_src_xtal,
    input  logic             cfg_wake_en,
    input  logic             cfg_irq_en,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_val,
    input  logic             flag_clr,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);
    import rtc_pkg::*;

    // settings, cleared by power-on reset only
    logic             run_q, src_q, wake_en_q, irq_en_q;
    logic [CNT_W-1:0] reload_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q     <= 1'b0;
            src_q     <= 1'b0;
            wake_en_q <= 1'b0;
            irq_en_q  <= 1'b0;
            reload_q  <= RELOAD_RST;
        end else begin
            if (cfg_we) begin
                run_q     <= cfg_run;
                src_q     <= cfg_src_xtal;
                wake_en_q <= cfg_wake_en;
                irq_en_q  <= cfg_irq_en;
            end
            if (rld_we) reload_q <= rld_val;
        end
    end

    // controller
    rtc_state_e state_q, state_d;
    logic       tick, load_cmd, step_cmd, zero_evt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (run_q) state_d = ST_LOAD;
            ST_LOAD: state_d = run_q ? ST_RUN : ST_OFF;
            ST_RUN:  if (!run_q) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        load_cmd = 1'b0;
        step_cmd = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_LOAD: load_cmd = 1'b1;
            ST_RUN:  step_cmd = tick;
            default: ;
        endcase
    end

    rtc_clk_pick u_pick (
        .core_tick   (core_tick),
        .xtal_tick   (xtal_tick),
        .src_xtal    (src_xtal_sel),
        .xtal_is_cpu (xtal_is_cpu),
        .tick        (tick)
    );

    logic src_xtal_sel;
    assign src_xtal_sel = src_q;

    rtc_chain #(
        .PRE_W   (PRE_W),
        .CNT_W   (CNT_W),
        .RST_CNT (RELOAD_RST)
    ) u_chain (
        .clk      (clk),
        .por_n    (por_n),
        .load     (load_cmd),
        .step     (step_cmd),
        .reload   (reload_q),
        .pre_q    (pre_o),
        .cnt_q    (cnt_o),
        .zero_evt (zero_evt)
    );

    rtc_flag_reg u_flag (
        .clk   (clk),
        .por_n (por_n),
        .set   (zero_evt),
        .clr   (flag_clr),
        .flag  (flag_o)
    );

    assign irq_o  = flag_o && irq_en_q;
    assign wake_o = flag_o && wake_en_q;
endmodule

// File: rtl/rtc_wake_chk.sv
module rtc_wake_chk #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic [1:0]       state_q,
    input logic [PRE_W-1:0] pre_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] reload_q,
    input logic             flag_o,
    input logic             flag_clr,
    input logic             irq_o,
    input logic             wake_o
);
    localparam logic [1:0] S_OFF  = 2'd0;
    localparam logic [1:0] S_LOAD = 2'd1;
    localparam logic [1:0] S_RUN  = 2'd2;
    localparam logic [PRE_W-1:0] TOP = '1;

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == S_RUN && pre_o != '0) |=> $stable(cnt_o));

    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_o) |-> (pre_o == TOP && cnt_o == $past(reload_q)));

    p_flag_fall_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(flag_o) |-> $past(flag_clr));

    p_req_idle_r7: assert property (@(posedge clk) disable iff (!por_n)
        !flag_o |-> (!irq_o && !wake_o));

    p_load_top_r8: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == S_LOAD) |=> (pre_o == TOP && cnt_o == $past(reload_q)));

    p_off_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == S_OFF) |=> ($stable(pre_o) && $stable(cnt_o)));

    p_reset_r1: assert property (@(posedge clk)
        !por_n |-> (state_q == S_OFF && !flag_o));
endmodule

bind rtc_wake_timer rtc_wake_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .state_q  (state_q),
    .pre_o    (pre_o),
    .cnt_o    (cnt_o),
    .reload_q (reload_q),
    .flag_o   (flag_o),
    .flag_clr (flag_clr),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
);

// File: tb/sim_rtc_wake_timer.sv
`timescale 1ns/1ps
module sim_rtc_wake_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        core_tick = 1'b0, xtal_tick = 1'b0, xtal_is_cpu = 1'b0;
    logic        cfg_we = 1'b0, cfg_run = 1'b0, cfg_src_xtal = 1'b0;
    logic        cfg_wake_en = 1'b0, cfg_irq_en = 1'b0;
    logic        rld_we = 1'b0;
    logic [15:0] rld_val = '0;
    logic        flag_clr = 1'b0;
    logic [6:0]  pre_o;
    logic [15:0] cnt_o;
    logic        flag_o, irq_o, wake_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_wake_timer u0 (
        .clk(clk), .por_n(por_n), .core_tick(core_tick), .xtal_tick(xtal_tick),
        .xtal_is_cpu(xtal_is_cpu), .cfg_we(cfg_we), .cfg_run(cfg_run),
        .cfg_src_xtal(cfg_src_xtal), .cfg_wake_en(cfg_wake_en), .cfg_irq_en(cfg_irq_en),
        .rld_we(rld_we), .rld_val(rld_val), .flag_clr(flag_clr),
        .pre_o(pre_o), .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input bit run, input bit src, input bit wk, input bit irq);
        cfg_we = 1'b1; cfg_run = run; cfg_src_xtal = src; cfg_wake_en = wk; cfg_irq_en = irq;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_reload(input logic [15:0] v);
        rld_we = 1'b1; rld_val = v;
        @(negedge clk);
        rld_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // enable and wait for the load cycle to complete (R8)
    task automatic start(input bit src, input bit wk, input bit irq);
        write_cfg(1'b1, src, wk, irq);
        wait_n(2);
    endtask

    task automatic stop();
        write_cfg(1'b0, cfg_src_xtal, cfg_wake_en, cfg_irq_en);
        wait_n(1);
    endtask

    task automatic t_reset();
        chk("R1 pre", pre_o, 7'd127);
        chk("R1 cnt", cnt_o, 16'hFFFF);
        chk("R1 flag", flag_o, 0);
        chk("R1 irq/wake", {irq_o, wake_o}, 0);
    endtask

    task automatic t_full_period();
        core_tick = 1'b1;
        write_reload(16'd2);
        start(1'b0, 1'b0, 1'b1);
        chk("R8 load pre", pre_o, 7'd127);
        chk("R8 load cnt", cnt_o, 16'd2);
        wait_n(1);
        chk("R2 first step", pre_o, 7'd126);
        wait_n(126);
        chk("R2 pre zero", pre_o, 7'd0);
        chk("R2 cnt held", cnt_o, 16'd2);
        wait_n(1);
        chk("R2 wrap pre", pre_o, 7'd127);
        chk("R2 wrap cnt", cnt_o, 16'd1);
        wait_n(255);
        chk("R3 all zero", {flag_o, cnt_o, 1'b0, pre_o}, 0);
        wait_n(1);
        chk("R3 reload cnt", cnt_o, 16'd2);
        chk("R3 reload pre", pre_o, 7'd127);
        chk("R3 flag set", flag_o, 1);
        chk("R7 irq", irq_o, 1);
        chk("R7 wake off", wake_o, 0);
    endtask

    task automatic t_flag_clear();
        wait_n(10);
        chk("R6 flag held", flag_o, 1);
        pulse_clr();
        chk("R6 flag cleared", flag_o, 0);
        chk("R7 irq cleared", irq_o, 0);
    endtask

    task automatic t_freeze();
        logic [6:0]  p;
        logic [15:0] c;
        stop();
        p = pre_o; c = cnt_o;
        wait_n(20);
        chk("R8 freeze pre", pre_o, p);
        chk("R8 freeze cnt", cnt_o, c);
    endtask

    task automatic t_collision();
        write_reload(16'd0);
        pulse_clr();
        start(1'b0, 1'b0, 1'b0);
        chk("R8 reload zero", cnt_o, 16'd0);
        wait_n(127);
        chk("R6 pre at zero", pre_o, 7'd0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 set beats clear", flag_o, 1);
        chk("R3 reload zero pre", pre_o, 7'd127);
        chk("R3 reload zero cnt", cnt_o, 16'd0);
    endtask

    task automatic t_source();
        core_tick = 1'b0; xtal_tick = 1'b0;
        stop();
        write_reload(16'd5);
        pulse_clr();
        start(1'b1, 1'b1, 1'b0);
        core_tick = 1'b1;
        wait_n(10);
        chk("R4 core ignored", pre_o, 7'd127);
        core_tick = 1'b0; xtal_tick = 1'b1;
        wait_n(10);
        chk("R4 xtal counts", pre_o, 7'd117);
        xtal_is_cpu = 1'b1;
        wait_n(10);
        chk("R5 xtal blocked", pre_o, 7'd117);
        xtal_tick = 1'b0; core_tick = 1'b1;
        wait_n(5);
        chk("R5 core forced", pre_o, 7'd112);
        core_tick = 1'b0;
    endtask

    task automatic t_reload_live();
        write_reload(16'd9);
        chk("R9 count kept", cnt_o, 16'd5);
        chk("R9 pre kept", pre_o, 7'd112);
        core_tick = 1'b1;
        wait_n(752);
        chk("R9 old period", {cnt_o, 1'b0, pre_o}, 0);
        chk("R7 wake idle", wake_o, 0);
        wait_n(1);
        chk("R9 new reload", cnt_o, 16'd9);
        chk("R7 wake", wake_o, 1);
        chk("R7 irq masked", irq_o, 0);
        core_tick = 1'b0;
    endtask

    initial begin
        wait_n(3);
        t_reset();
        por_n = 1'b1;
        wait_n(1);
        t_full_period();
        t_flag_clear();
        t_freeze();
        t_collision();
        t_source();
        t_reload_live();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(50000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule